// File: doc/BRIEF.md
# Bus-to-Memory Width Adaptation Bridge

This block connects a 32-bit system-bus slave port to an external static memory with a fixed data path of 8 or 16 bits. Each bus request is one transfer of a byte, a halfword or a word. The bridge turns it into as many memory accesses as the memory width needs. It drives the address, the write data and the active-low byte-lane enables for each access. On reads it gathers the returned pieces into one bus word. A single bus clock drives all sequencing, and each memory access takes exactly one clock cycle.

Two configuration inputs describe the attached device. `cfg_wide` selects a 16-bit memory when high and an 8-bit memory when low. `cfg_lanes` tells the bridge whether a 16-bit device honours byte-lane enables. A 16-bit device without byte lanes can only move whole words. On such a device a byte read fetches the full word and returns only the addressed byte, while a byte write is refused with an error response and no memory strobe. Both configuration inputs and the request fields are sampled when a request is accepted. A request is accepted on a clock edge where `req_valid` and `bus_ready` are both high. Bus addresses must be aligned to the transfer size.

Top module: `busmem_width_bridge`

## Requirements
- R1: During and right after reset, `bus_ready` is 1, `rsp_err` is 0, `mem_cs` is 0 and `mem_be_n` is 2'b11.
- R2: When the transfer size equals the memory width, exactly one access is made. A halfword on a 16-bit memory drives `mem_be_n` = 2'b00.
- R3: A wider transfer is split into consecutive accesses, each one memory word wide. A word on a 16-bit memory takes 2 accesses, a word on an 8-bit memory takes 4, and a halfword on an 8-bit memory takes 2. The least significant part goes first.
- R4: The address of access k is the bus byte address shifted right by 1 (16-bit memory) or by 0 (8-bit memory), plus k.
- R5: A byte transfer on a 16-bit memory with byte lanes makes one access. `mem_be_n` is 2'b10 for an even address and 2'b01 for an odd address, and the written byte appears on the enabled lane. Lane 0 is `mem_wdata[7:0]` and lane 1 is `mem_wdata[15:8]`.
- R6: A byte write to a 16-bit memory without byte lanes raises no `mem_cs` at all. It gives `rsp_err` = 1 with `bus_ready` = 0 in the first cycle after acceptance, then `rsp_err` = 1 with `bus_ready` = 1 in the second. Memory contents stay unchanged.
- R7: A byte read from a 16-bit memory without byte lanes makes one access with `mem_be_n` = 2'b00. It returns the upper half of the word for an odd address and the lower half for an even one.
- R8: Read data is right-justified in `rsp_rdata`, with unused upper bits zero, and the parts are placed little-endian. It is valid while `bus_ready` is high after the request.
- R9: `bus_ready` is low from the cycle after acceptance until the cycle after the last access, so n accesses give ready again n+1 cycles after acceptance. `mem_cs` is never high while `bus_ready` is high.
- R10: A request with the reserved size code 2'b11 gets the same error response as R6, with no memory access. Size codes are 0 for a byte, 1 for a halfword and 2 for a word.
- R11: On an 8-bit memory every access drives `mem_be_n` = 2'b10 and carries its byte on lane 0.

Size code 2'b11 is reserved (R10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1: 16-bit memory, 0: 8-bit memory |
| cfg_lanes | input | 1 | 1: a 16-bit memory honours byte-lane enables |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Bus byte address, aligned to the size |
| req_wdata | input | 32 | Write data, right-justified |
| bus_ready | output | 1 | High when idle or when a response completes |
| rsp_err | output | 1 | Error response flag |
| rsp_rdata | output | 32 | Assembled read data |
| mem_cs | output | 1 | Memory access strobe, one cycle per access |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be_n | output | 2 | Active-low byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, sampled during the access cycle |

## Verification
A wrong sub-access counter shows up at the ports within one access. It produces either a non-consecutive `mem_addr` or a burst length that differs from the transfer-to-width ratio. The ready pulse then arrives early or late against the n+1 cycle rule. Wrong lane selection or capture slot shows up as a corrupted `rsp_rdata` byte in the completion cycle of the same request. A wrong data slice on writes is caught on the first read of that location. A bad error decision is visible within two cycles, either as a strobe on a refused request or as a missing `rsp_err` pair.

// File: rtl/bw_pkg.sv
package bw_pkg;
   localparam int BUS_DW    = 32;
   localparam int MEM_DW    = 16;
   localparam int BUS_BYTES = BUS_DW / 8;
   localparam int MEM_BYTES = MEM_DW / 8;
   localparam int MAX_SUB   = BUS_BYTES;
   localparam int IDX_W     = $clog2(MAX_SUB);

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } bw_size_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACC  = 3'd1,
      ST_DONE = 3'd2,
      ST_ERR1 = 3'd3,
      ST_ERR2 = 3'd4
   } bw_state_e;
endpackage

// File: rtl/bw_planner.sv
module bw_planner
   import bw_pkg::*;
#(
   parameter int IDX_W_P = IDX_W
)(
   input  logic               wide,
   input  logic               lanes,
   input  logic               write,
   input  logic               byte_hi,
   input  logic [1:0]         size,
   output logic               reject,
   output logic [IDX_W_P-1:0] last_idx,
   output logic [1:0]         be_n
);
   bw_size_e sz;
   logic     narrow_byte;

   assign sz          = bw_size_e'(size);
   assign narrow_byte = wide && (sz == SZ_BYTE);

   always_comb begin
      last_idx = '0;
      if (wide) begin
         if (sz == SZ_WORD) last_idx = IDX_W_P'(1);
      end else begin
         case (sz)
            SZ_WORD: last_idx = IDX_W_P'(3);
            SZ_HALF: last_idx = IDX_W_P'(1);
            default: last_idx = '0;
         endcase
      end
   end

   always_comb begin
      if (!wide)
         be_n = 2'b10;
      else if (narrow_byte && lanes)
         be_n = byte_hi ? 2'b01 : 2'b10;
      else
         be_n = 2'b00;
   end

   assign reject = (sz == SZ_RSVD) || (narrow_byte && !lanes && write);
endmodule

// File: rtl/bw_sequencer.sv
module bw_sequencer
   import bw_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int IDX_W_P = IDX_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [BUS_DW-1:0]  req_wdata,
   input  logic               cfg_wide,
   input  logic               plan_reject,
   input  logic [IDX_W_P-1:0] plan_last,
   input  logic [1:0]         plan_be_n,
   output logic               bus_ready,
   output logic               rsp_err,
   output logic               start,
   output logic               acc_on,
   output logic [IDX_W_P-1:0] acc_idx,
   output logic               q_write,
   output logic               q_wide,
   output bw_size_e           q_size,
   output logic               q_byte_hi,
   output logic [1:0]         q_be_n,
   output logic [ADDR_W-1:0]  q_base,
   output logic [BUS_DW-1:0]  q_wdata
);
   bw_state_e          st_q;
   logic [IDX_W_P-1:0] last_q;

   assign bus_ready = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR2);
   assign rsp_err   = (st_q == ST_ERR1) || (st_q == ST_ERR2);
   assign acc_on    = (st_q == ST_ACC);
   assign start     = req_valid && bus_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         acc_idx   <= '0;
         last_q    <= '0;
         q_write   <= 1'b0;
         q_wide    <= 1'b0;
         q_size    <= SZ_BYTE;
         q_byte_hi <= 1'b0;
         q_be_n    <= 2'b11;
         q_base    <= '0;
         q_wdata   <= '0;
      end else begin
         case (st_q)
            ST_ACC: begin
               if (acc_idx == last_q) st_q <= ST_DONE;
               else                   acc_idx <= acc_idx + IDX_W_P'(1);
            end
            ST_ERR1: st_q <= ST_ERR2;
            default: begin
               if (start) begin
                  acc_idx   <= '0;
                  last_q    <= plan_last;
                  q_write   <= req_write;
                  q_wide    <= cfg_wide;
                  q_size    <= bw_size_e'(req_size);
                  q_byte_hi <= req_addr[0];
                  q_be_n    <= plan_be_n;
                  q_base    <= cfg_wide ? (req_addr >> 1) : req_addr;
                  q_wdata   <= req_wdata;
                  st_q      <= plan_reject ? ST_ERR1 : ST_ACC;
               end else begin
                  st_q <= ST_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/bw_lane_mux.sv
module bw_lane_mux
   import bw_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int IDX_W_P = IDX_W
)(
   input  logic               acc_on,
   input  logic [IDX_W_P-1:0] acc_idx,
   input  logic               q_write,
   input  logic               q_wide,
   input  bw_size_e           q_size,
   input  logic [1:0]         q_be_n,
   input  logic [ADDR_W-1:0]  q_base,
   input  logic [BUS_DW-1:0]  q_wdata,
   output logic               mem_cs,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [1:0]         mem_be_n,
   output logic [MEM_DW-1:0]  mem_wdata
);
   logic [7:0]        nb;
   logic [MEM_DW-1:0] hw;

   assign nb = q_wdata[{acc_idx, 3'b000} +: 8];
   assign hw = q_wdata[{acc_idx[0], 4'b0000} +: MEM_DW];

   assign mem_cs   = acc_on;
   assign mem_we   = acc_on && q_write;
   assign mem_addr = acc_on ? (q_base + ADDR_W'(acc_idx)) : '0;
   assign mem_be_n = acc_on ? q_be_n : 2'b11;

   always_comb begin
      if (!acc_on)
         mem_wdata = '0;
      else if (!q_wide)
         mem_wdata = {nb, nb};
      else if (q_size == SZ_BYTE)
         mem_wdata = {q_wdata[7:0], q_wdata[7:0]};
      else
         mem_wdata = hw;
   end
endmodule

// File: rtl/bw_assembler.sv
module bw_assembler
   import bw_pkg::*;
#(
   parameter int IDX_W_P = IDX_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               capture,
   input  logic               q_wide,
   input  bw_size_e           q_size,
   input  logic               q_byte_hi,
   input  logic [IDX_W_P-1:0] acc_idx,
   input  logic [MEM_DW-1:0]  mem_rdata,
   output logic [BUS_DW-1:0]  hold
);
   for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
      logic       en;
      logic [7:0] val;
      logic [7:0] byte_q;

      always_comb begin
         if (!q_wide) begin
            en  = (acc_idx == IDX_W_P'(j));
            val = mem_rdata[7:0];
         end else if (q_size == SZ_BYTE) begin
            en  = (j == 0);
            val = q_byte_hi ? mem_rdata[15:8] : mem_rdata[7:0];
         end else begin
            en  = (acc_idx == IDX_W_P'(j / 2));
            val = mem_rdata[8*(j%2) +: 8];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              byte_q <= '0;
         else if (clear)          byte_q <= '0;
         else if (capture && en)  byte_q <= val;
      end

      assign hold[8*j +: 8] = byte_q;
   end
endmodule

// File: rtl/busmem_width_bridge.sv
module busmem_width_bridge
   import bw_pkg::*;
#(
   parameter int ADDR_W = 24
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic              cfg_lanes,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              bus_ready,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              mem_cs,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_be_n,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("busmem_width_bridge: ADDR_W must be at least 4");
   end
   if (BUS_DW != 2 * MEM_DW || MEM_BYTES != 2) begin : g_bad_width
      $error("busmem_width_bridge: bus must be twice the widest memory");
   end

   logic             plan_reject;
   logic [IDX_W-1:0] plan_last;
   logic [1:0]       plan_be_n;
   logic             start;
   logic             acc_on;
   logic [IDX_W-1:0] acc_idx;
   logic             q_write;
   logic             q_wide;
   bw_size_e         q_size;
   logic             q_byte_hi;
   logic [1:0]       q_be_n;
   logic [ADDR_W-1:0] q_base;
   logic [31:0]      q_wdata;

   bw_planner #(.IDX_W_P(IDX_W)) u_plan (
      .wide     (cfg_wide),
      .lanes    (cfg_lanes),
      .write    (req_write),
      .byte_hi  (req_addr[0]),
      .size     (req_size),
      .reject   (plan_reject),
      .last_idx (plan_last),
      .be_n     (plan_be_n)
   );

   bw_sequencer #(.ADDR_W(ADDR_W), .IDX_W_P(IDX_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_size    (req_size),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .cfg_wide    (cfg_wide),
      .plan_reject (plan_reject),
      .plan_last   (plan_last),
      .plan_be_n   (plan_be_n),
      .bus_ready   (bus_ready),
      .rsp_err     (rsp_err),
      .start       (start),
      .acc_on      (acc_on),
      .acc_idx     (acc_idx),
      .q_write     (q_write),
      .q_wide      (q_wide),
      .q_size      (q_size),
      .q_byte_hi   (q_byte_hi),
      .q_be_n      (q_be_n),
      .q_base      (q_base),
      .q_wdata     (q_wdata)
   );

   bw_lane_mux #(.ADDR_W(ADDR_W), .IDX_W_P(IDX_W)) u_mux (
      .acc_on    (acc_on),
      .acc_idx   (acc_idx),
      .q_write   (q_write),
      .q_wide    (q_wide),
      .q_size    (q_size),
      .q_be_n    (q_be_n),
      .q_base    (q_base),
      .q_wdata   (q_wdata),
      .mem_cs    (mem_cs),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_be_n  (mem_be_n),
      .mem_wdata (mem_wdata)
   );

   bw_assembler #(.IDX_W_P(IDX_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .capture   (acc_on && !q_write),
      .q_wide    (q_wide),
      .q_size    (q_size),
      .q_byte_hi (q_byte_hi),
      .acc_idx   (acc_idx),
      .mem_rdata (mem_rdata),
      .hold      (rsp_rdata)
   );
endmodule

// File: rtl/bw_checker.sv
module bw_checker #(
   parameter int ADDR_W = 24
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wide,
   input logic              bus_ready,
   input logic              rsp_err,
   input logic              mem_cs,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_be_n
);
   logic [2:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (mem_cs) run_q <= run_q + 3'd1;
      else             run_q <= '0;
   end

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (bus_ready && !rsp_err && !mem_cs && mem_be_n == 2'b11));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs |-> !bus_ready);

   p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs) |-> (bus_ready && !rsp_err));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && $past(mem_cs)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs |-> (run_q < (cfg_wide ? 3'd2 : 3'd4)));

   p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> !mem_cs);

   p_err_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err && !bus_ready) |=> (rsp_err && bus_ready));

   p_lane_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs |-> (mem_be_n != 2'b11));

   p_narrow_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && !cfg_wide) |-> (mem_be_n == 2'b10));
endmodule

bind busmem_width_bridge bw_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wide  (cfg_wide),
   .bus_ready (bus_ready),
   .rsp_err   (rsp_err),
   .mem_cs    (mem_cs),
   .mem_addr  (mem_addr),
   .mem_be_n  (mem_be_n)
);

// File: tb/sim_busmem_width_bridge.sv
module sim_busmem_width_bridge;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wide = 1'b1, cfg_lanes = 1'b1;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          bus_ready, rsp_err, mem_cs, mem_we;
   logic [31:0]   rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_be_n;
   logic [15:0]   mem_wdata, mem_rdata;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   busmem_width_bridge #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_lanes(cfg_lanes),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata), .bus_ready(bus_ready),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_cs(mem_cs), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   // memory model
   logic [15:0] dev_mem [0:511];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) dev_mem[i] <= 16'(i * 16'h9e37 + 16'h1234);
      end else if (mem_cs && mem_we) begin
         if (!mem_be_n[0]) dev_mem[mem_addr[8:0]][7:0]  <= mem_wdata[7:0];
         if (!mem_be_n[1]) dev_mem[mem_addr[8:0]][15:8] <= mem_wdata[15:8];
      end
   end
   assign mem_rdata = (mem_cs && !mem_we) ? dev_mem[mem_addr[8:0]] : 16'h0;

   // access log
   int          log_n = 0;
   logic [AW-1:0] log_addr [8];
   logic [1:0]  log_be [8];
   logic [15:0] log_wd [8];
   logic        log_we [8];
   always @(negedge clk) begin
      if (mem_cs && log_n < 8) begin
         log_addr[log_n] = mem_addr;
         log_be[log_n]   = mem_be_n;
         log_wd[log_n]   = mem_wdata;
         log_we[log_n]   = mem_we;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int subs(input logic wide, input logic [1:0] sz);
      int mb = wide ? 2 : 1;
      int sb = 1 << sz;
      return (sb > mb) ? sb / mb : 1;
   endfunction

   function automatic logic [1:0] exp_be(input logic wide, input logic lanes,
                                         input logic [1:0] sz, input logic a0);
      if (!wide) return 2'b10;
      if (sz == 2'd0) return lanes ? (a0 ? 2'b01 : 2'b10) : 2'b00;
      return 2'b00;
   endfunction

   task automatic run_txn(input logic w, input logic [1:0] sz, input logic [8:0] a,
                          input logic [31:0] wd, input logic wide, input logic lanes);
      bit          err_exp;
      int          n, lat;
      logic [31:0] e_rd;
      logic [1:0]  ebe;
      logic [15:0] ew;
      logic [15:0] wv;
      err_exp = (sz == 2'd3) || (wide && !lanes && sz == 2'd0 && w);
      n   = subs(wide, sz);
      ebe = exp_be(wide, lanes, sz, a[0]);
      @(negedge clk);
      while (!bus_ready) @(negedge clk);
      e_rd = '0;
      if (!wide) begin
         for (int k = 0; k < n; k++) e_rd[8*k +: 8] = dev_mem[9'(a + 9'(k))][7:0];
      end else if (sz == 2'd0) begin
         wv = dev_mem[{1'b0, a[8:1]}];
         e_rd[7:0] = a[0] ? wv[15:8] : wv[7:0];
      end else begin
         for (int k = 0; k < n; k++) e_rd[16*k +: 16] = dev_mem[9'({1'b0, a[8:1]} + 9'(k))];
      end
      cfg_wide = wide; cfg_lanes = lanes; log_n = 0;
      req_valid = 1'b1; req_write = w; req_size = sz;
      req_addr = AW'(a); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      if (err_exp) begin
         chk(rsp_err && !bus_ready, (sz == 2'd3) ? "R10" : "R6", "error first cycle",
             {30'd0, rsp_err, bus_ready}, 32'h2);
         @(negedge clk);
         chk(rsp_err && bus_ready, (sz == 2'd3) ? "R10" : "R6", "error second cycle",
             {30'd0, rsp_err, bus_ready}, 32'h3);
         chk(log_n == 0, "R6", "strobes on refused request", log_n, 0);
      end else begin
         while (!bus_ready && lat < 20) begin
            @(negedge clk);
            lat++;
         end
         chk(lat == n + 1, "R9", "ready latency", lat, n + 1);
         chk(!rsp_err, "R9", "no error on legal request", rsp_err, 0);
         chk(log_n == n, (n == 1) ? "R2" : "R3", "access count", log_n, n);
         for (int k = 0; k < n && k < log_n; k++) begin
            chk(log_addr[k] == AW'((wide ? (a >> 1) : a) + 9'(k)), "R4", "memory address",
                32'(log_addr[k]), 32'((wide ? (a >> 1) : a) + 9'(k)));
            chk(log_be[k] == ebe, !wide ? "R11" : (sz == 2'd0 ? (lanes ? "R5" : "R7") : "R2"),
                "lane enables", log_be[k], ebe);
            chk(log_we[k] == w, "R3", "write enable", log_we[k], w);
            if (w) begin
               if (!wide)            ew = {8'h00, wd[8*k +: 8]};
               else if (sz == 2'd0)  ew = {wd[7:0], wd[7:0]};
               else                  ew = wd[16*k +: 16];
               if (!ebe[0]) chk(log_wd[k][7:0] == ew[7:0], wide ? "R5" : "R11",
                                "lane0 write data", log_wd[k][7:0], ew[7:0]);
               if (!ebe[1]) chk(log_wd[k][15:8] == ew[15:8], "R3",
                                "lane1 write data", log_wd[k][15:8], ew[15:8]);
            end
         end
         if (!w) chk(rsp_rdata == e_rd, (wide && sz == 2'd0 && !lanes) ? "R7" : "R8",
                     "read data", rsp_rdata, e_rd);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk(bus_ready && !rsp_err && !mem_cs && mem_be_n == 2'b11, "R1", "during reset",
          {27'd0, bus_ready, rsp_err, mem_cs, mem_be_n}, 32'h13);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_ready && !rsp_err && !mem_cs && mem_be_n == 2'b11, "R1", "after reset",
          {27'd0, bus_ready, rsp_err, mem_cs, mem_be_n}, 32'h13);

      // directed corners
      run_txn(1, 2'd1, 9'h010, 32'h0000_beef, 1, 1);   // R2 halfword on 16-bit
      run_txn(0, 2'd1, 9'h010, 32'h0, 1, 1);
      run_txn(1, 2'd2, 9'h020, 32'hcafe_f00d, 1, 1);   // R3 2 on 16
      run_txn(0, 2'd2, 9'h020, 32'h0, 1, 1);
      chk(rsp_rdata == 32'hcafe_f00d, "R8", "word readback 16-bit", rsp_rdata, 32'hcafe_f00d);
      run_txn(1, 2'd2, 9'h104, 32'h1122_3344, 0, 0);   // R3 4 on 8
      run_txn(0, 2'd2, 9'h104, 32'h0, 0, 0);
      chk(rsp_rdata == 32'h1122_3344, "R11", "word readback 8-bit", rsp_rdata, 32'h1122_3344);
      run_txn(1, 2'd1, 9'h106, 32'h0000_5a6b, 0, 1);   // R3 2 on 8
      run_txn(0, 2'd0, 9'h107, 32'h0, 0, 1);
      chk(rsp_rdata == 32'h0000_005a, "R11", "byte read 8-bit", rsp_rdata, 32'h5a);
      run_txn(1, 2'd0, 9'h041, 32'h0000_00a7, 1, 1);   // R5 odd lane
      run_txn(1, 2'd0, 9'h040, 32'h0000_0031, 1, 1);   // R5 even lane
      run_txn(0, 2'd1, 9'h040, 32'h0, 1, 1);
      chk(rsp_rdata == 32'h0000_a731, "R5", "byte lanes merged", rsp_rdata, 32'h0000_a731);
      run_txn(1, 2'd1, 9'h060, 32'h0000_9876, 1, 0);
      run_txn(1, 2'd0, 9'h061, 32'h0000_00ff, 1, 0);   // R6 refused
      run_txn(0, 2'd1, 9'h060, 32'h0, 1, 0);
      chk(rsp_rdata == 32'h0000_9876, "R6", "memory untouched by refused write",
          rsp_rdata, 32'h0000_9876);
      run_txn(0, 2'd0, 9'h061, 32'h0, 1, 0);           // R7 odd byte read
      chk(rsp_rdata == 32'h0000_0098, "R7", "upper byte returned", rsp_rdata, 32'h98);
      run_txn(0, 2'd0, 9'h060, 32'h0, 1, 0);
      chk(rsp_rdata == 32'h0000_0076, "R7", "lower byte returned", rsp_rdata, 32'h76);
      run_txn(0, 2'd3, 9'h080, 32'h0, 1, 1);           // R10 reserved
      run_txn(1, 2'd3, 9'h080, 32'h1, 0, 1);

      // constrained random
      for (int t = 0; t < 400; t++) begin
         logic [1:0] sz;
         logic [8:0] a;
         r  = $urandom;
         sz = (r[3:0] == 4'hf) ? 2'd3 : 2'(r[5:4] % 3);
         a  = 9'($urandom);
         if (sz == 2'd1) a[0] = 1'b0;
         if (sz >= 2'd2) a[1:0] = 2'b00;
         run_txn(r[6], sz, a, $urandom, r[7], r[8]);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule